// File: doc/BRIEF.md
# Receive Frame Synchronizer and Word Packer

This block sits behind an 8b/10b receive decoder. Each cycle it may accept one decoded byte together with a flag that marks control (K) characters. It looks for a programmable start delimiter and a programmable end delimiter, each a run of one to three K characters. It assembles the bytes it keeps into 32-bit words and writes them into an internal receive FIFO. Software or a DMA engine drains that FIFO through a simple read port. A one-cycle interrupt pulse marks each completed frame.

The block has two capture modes. Raw mode keeps every byte and widens each one to a 9-bit entry that carries its K flag, so the stream can be studied before its framing is known. Packed mode keeps only the data bytes that fall inside a frame and places four of them in each word. A loopback switch routes words from the transmit side directly into the receive FIFO, so the 32-bit path can be tested without a link.

Top module: `rx_frame_packer`

## Requirements
- R1: The start delimiter is a run of `sof_len` (1 to 3) K characters. Character i is held in `sof_seq[8i+7:8i]`, and character 0 arrives first. A byte matches only when `in_k` is high and its value equals the expected character. In packed mode, bytes that arrive before the delimiter completes are discarded.
- R2: When a match is only partial and then fails, the matcher restarts. The byte that broke the match is tested again as a possible first character of the delimiter.
- R3: The end delimiter (`eof_len`, `eof_seq`, same layout as R1) ends a frame only while a frame is open. `frame_irq` is high for exactly the one cycle after the clock edge that accepts the last delimiter byte.
- R4: In packed mode (`cfg_pack`=1), only non-K bytes inside a frame are stored. Four bytes fill a word, and the first byte to arrive goes in bits 7:0. A full word carries count 4.
- R5: In raw mode (`cfg_pack`=0), every byte is stored as the entry {K flag, byte}, whether or not a frame is open. Three entries fill a word, in bits 8:0, 17:9 and 26:18 in order of arrival. Bits 31:27 are zero.
- R6: At the end of a frame, a partly filled word is written with zero padding. Its count field `rd_cnt` gives the number of valid entries.
- R7: A write attempted while the FIFO is full is lost. It sets the sticky `overrun` output, closes the frame, and causes bytes to be dropped until the next start delimiter. No `frame_irq` fires for the lost frame.
- R8: With `cfg_loop`=1, each `tx_valid` word is written unchanged with count 4, and the byte input has no effect.
- R9: After reset, the FIFO is empty and `frame_irq` and `overrun` are low.
- R10: A read with `rd_en` while the FIFO is not empty gives `rd_valid` with the oldest word on the next cycle. A read of an empty FIFO gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded byte present |
| in_data | input | 8 | Decoded byte value |
| in_k | input | 1 | Byte is a K character |
| cfg_pack | input | 1 | 1 = packed mode, 0 = raw mode |
| cfg_loop | input | 1 | Transmit-to-receive loopback |
| sof_len | input | 2 | Start delimiter length (1..3) |
| sof_seq | input | 24 | Start delimiter characters |
| eof_len | input | 2 | End delimiter length (1..3) |
| eof_seq | input | 24 | End delimiter characters |
| tx_valid | input | 1 | Loopback word present |
| tx_data | input | 32 | Loopback word |
| rd_en | input | 1 | FIFO read request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read word |
| rd_cnt | output | 3 | Valid entries in read word |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| frame_irq | output | 1 | Frame complete pulse |
| overrun | output | 1 | Sticky FIFO overflow flag |

## Verification
Faults in the matcher state appear at the ports as a frame that never opens, or that opens one byte late. That shows up as missing words or a missing `frame_irq` pulse in the cycle after the delimiter. A wrong fill count in the packer moves every later byte to the wrong lane or gives a wrong `rd_cnt`, which is visible on the very next word read. A fault in the frame or drop flags leaves extra words in the FIFO or lets `overrun` clear. The bench catches these by reading back every word and by confirming that the FIFO is empty after stimulus that should have been dropped.

// File: rtl/rxfp_pkg.sv
package rxfp_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int ENT_W      = BYTE_W + 1;
  localparam int PACK_SLOTS = WORD_W / BYTE_W;
  localparam int RAW_SLOTS  = WORD_W / ENT_W;
  localparam int CNT_W      = $clog2(PACK_SLOTS + 1);
  localparam int SEQ_MAX    = 3;
  localparam int LEN_W      = $clog2(SEQ_MAX + 1);

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word;
  } fifo_ent_t;
endpackage

// File: rtl/rxfp_delim_match.sv
module rxfp_delim_match
  import rxfp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step,
  input  logic [BYTE_W-1:0]         data,
  input  logic                      is_k,
  input  logic [LEN_W-1:0]          len,
  input  logic [SEQ_MAX*BYTE_W-1:0] seq,
  output logic                      hit
);
  localparam int IDX_W = $clog2(SEQ_MAX);
  localparam int NSLOT = 1 << IDX_W;

  logic [BYTE_W-1:0] chr [NSLOT];
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  eff_len;

  for (genvar i = 0; i < NSLOT; i++) begin : g_chr
    if (i < SEQ_MAX) begin : g_used
      assign chr[i] = seq[i*BYTE_W +: BYTE_W];
    end else begin : g_pad
      assign chr[i] = '0;
    end
  end

  always_comb begin
    eff_len = (len == '0) ? LEN_W'(1) : len;
    hit     = 1'b0;
    idx_d   = idx_q;
    if (step) begin
      if (is_k && data == chr[idx_q]) begin
        if (LEN_W'(idx_q) + LEN_W'(1) == eff_len) begin
          hit   = 1'b1;
          idx_d = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end else if (is_k && data == chr[0]) begin
        // broken run: the offending byte may open a new one
        idx_d = IDX_W'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end
endmodule

// File: rtl/rxfp_packer.sv
module rxfp_packer
  import rxfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              raw_mode,
  input  logic              ent_valid,
  input  logic              ent_k,
  input  logic [BYTE_W-1:0] ent_data,
  input  logic              flush,
  output logic              push,
  output fifo_ent_t         push_ent
);
  logic [WORD_W-1:0] acc_q, acc_add, ent_ext;
  logic [CNT_W-1:0]  n_q, n_add, cap;
  int                sh;

  always_comb begin
    cap     = raw_mode ? CNT_W'(RAW_SLOTS) : CNT_W'(PACK_SLOTS);
    ent_ext = raw_mode ? WORD_W'({ent_k, ent_data}) : WORD_W'(ent_data);
    sh      = raw_mode ? int'(n_q) * ENT_W : int'(n_q) * BYTE_W;
    acc_add = acc_q;
    n_add   = n_q;
    if (ent_valid) begin
      acc_add = acc_q | (ent_ext << sh);
      n_add   = n_q + CNT_W'(1);
    end
    push          = (n_add == cap) || (flush && n_add != '0);
    push_ent.cnt  = n_add;
    push_ent.word = acc_add;
  end

  always_ff @(posedge clk) begin
    if (rst || clear || push) begin
      acc_q <= '0;
      n_q   <= '0;
    end else begin
      acc_q <= acc_add;
      n_q   <= n_add;
    end
  end
endmodule

// File: rtl/rxfp_fifo.sv
module rxfp_fifo
  import rxfp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  fifo_ent_t wdata,
  input  logic      rd,
  output fifo_ent_t rdata,
  output logic      rvalid,
  output logic      empty,
  output logic      full
);
  localparam int AW = $clog2(DEPTH);

  fifo_ent_t      mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [AW:0]    cnt_q;
  logic           do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
    if (do_rd) rdata <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (do_wr) wp_q <= wp_q + AW'(1);
      if (do_rd) rp_q <= rp_q + AW'(1);
      cnt_q  <= cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
      rvalid <= do_rd;
    end
  end
endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxfp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [BYTE_W-1:0]         in_data,
  input  logic                      in_k,
  input  logic                      cfg_pack,
  input  logic                      cfg_loop,
  input  logic [LEN_W-1:0]          sof_len,
  input  logic [SEQ_MAX*BYTE_W-1:0] sof_seq,
  input  logic [LEN_W-1:0]          eof_len,
  input  logic [SEQ_MAX*BYTE_W-1:0] eof_seq,
  input  logic                      tx_valid,
  input  logic [WORD_W-1:0]         tx_data,
  input  logic                      rd_en,
  output logic                      rd_valid,
  output logic [WORD_W-1:0]         rd_data,
  output logic [CNT_W-1:0]          rd_cnt,
  output logic                      fifo_empty,
  output logic                      fifo_full,
  output logic                      frame_irq,
  output logic                      overrun
);
  logic      byte_step, sof_hit, eof_hit, sof_go, eof_go;
  logic      in_frame_q, drop_q, overrun_q, irq_q;
  logic      keep, pk_push, fifo_wr, overflow;
  fifo_ent_t pk_ent, wr_ent, rd_ent;

  assign byte_step = in_valid && !cfg_loop;

  rxfp_delim_match u_sof (
    .clk(clk), .rst(rst), .step(byte_step), .data(in_data), .is_k(in_k),
    .len(sof_len), .seq(sof_seq), .hit(sof_hit)
  );

  rxfp_delim_match u_eof (
    .clk(clk), .rst(rst), .step(byte_step), .data(in_data), .is_k(in_k),
    .len(eof_len), .seq(eof_seq), .hit(eof_hit)
  );

  assign sof_go = sof_hit && !in_frame_q;
  assign eof_go = eof_hit && in_frame_q;

  always_comb begin
    if (cfg_pack) keep = in_frame_q && !in_k;
    else          keep = !drop_q || sof_go;
  end

  rxfp_packer u_pack (
    .clk(clk), .rst(rst), .clear(cfg_loop), .raw_mode(!cfg_pack),
    .ent_valid(byte_step && keep), .ent_k(in_k), .ent_data(in_data),
    .flush(eof_go), .push(pk_push), .push_ent(pk_ent)
  );

  always_comb begin
    if (cfg_loop) begin
      fifo_wr     = tx_valid;
      wr_ent.cnt  = CNT_W'(PACK_SLOTS);
      wr_ent.word = tx_data;
    end else begin
      fifo_wr = pk_push;
      wr_ent  = pk_ent;
    end
  end

  assign overflow = fifo_wr && fifo_full;

  rxfp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(fifo_wr), .wdata(wr_ent), .rd(rd_en),
    .rdata(rd_ent), .rvalid(rd_valid), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      overrun_q  <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= eof_go && !overflow;
      if (overflow) begin
        overrun_q  <= 1'b1;
        drop_q     <= 1'b1;
        in_frame_q <= 1'b0;
      end else if (sof_go) begin
        in_frame_q <= 1'b1;
        drop_q     <= 1'b0;
      end else if (eof_go) begin
        in_frame_q <= 1'b0;
      end
    end
  end

  assign rd_data   = rd_ent.word;
  assign rd_cnt    = rd_ent.cnt;
  assign frame_irq = irq_q;
  assign overrun   = overrun_q;
endmodule

// File: rtl/rxfp_checker.sv
module rxfp_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_loop,
  input logic        tx_valid,
  input logic        rd_en,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic [2:0]  rd_cnt,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic        frame_irq,
  input logic        overrun
);
  // R3: completion pulse lasts one cycle
  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);

  // R7: overrun stays set once raised
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R7: overrun only rises after a full FIFO
  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(fifo_full));

  // R10: read data only follows an accepted read
  p_rdvalid_cause_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !fifo_empty));

  // R6: count field is always within one word
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_cnt != 3'd0 && rd_cnt <= 3'd4));

  // R5: words short of four entries carry zero in the top bits
  p_raw_pad_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_cnt <= 3'd3) |-> rd_data[31:27] == 5'd0);

  // R8: loopback without tx words leaves the FIFO level alone
  p_loop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_loop && !tx_valid && !rd_en) |=> ($stable(fifo_empty) && $stable(fifo_full)));
endmodule

bind rx_frame_packer rxfp_checker u_chk (.*);

// File: tb/rx_frame_packer_test.sv
`timescale 1ns/1ps
module rx_frame_packer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_k, cfg_pack, cfg_loop, tx_valid, rd_en;
  logic [7:0]  in_data;
  logic [1:0]  sof_len, eof_len;
  logic [23:0] sof_seq, eof_seq;
  logic [31:0] tx_data;
  logic        rd_valid, fifo_empty, fifo_full, frame_irq, overrun;
  logic [31:0] rd_data;
  logic [2:0]  rd_cnt;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_frame_packer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_k(in_k),
    .cfg_pack(cfg_pack), .cfg_loop(cfg_loop), .sof_len(sof_len), .sof_seq(sof_seq),
    .eof_len(eof_len), .eof_seq(eof_seq), .tx_valid(tx_valid), .tx_data(tx_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_cnt(rd_cnt),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .frame_irq(frame_irq),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pack);
    rst = 1'b1; cfg_pack = pack; cfg_loop = 1'b0;
    in_valid = 1'b0; in_k = 1'b0; in_data = '0; tx_valid = 1'b0; tx_data = '0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic k, input logic [7:0] d);
    in_valid = 1'b1; in_k = k; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_k = 1'b0;
  endtask

  task automatic send_sof();
    put(1, 8'hBC); put(1, 8'h3C); put(1, 8'h7C);
  endtask

  task automatic pop(input string tag, input logic [31:0] w, input logic [2:0] c);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " valid"}, 64'(rd_valid), 64'd1);
    chk({tag, " word"}, 64'(rd_data), 64'(w));
    chk({tag, " cnt"}, 64'(rd_cnt), 64'(c));
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R9 empty", 64'(fifo_empty), 64'd1);
    chk("R9 full", 64'(fifo_full), 64'd0);
    chk("R9 irq", 64'(frame_irq), 64'd0);
    chk("R9 overrun", 64'(overrun), 64'd0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R10 read of empty", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_packed();
    do_reset(1'b1);
    put(1, 8'h1C); put(0, 8'h11);               // before start: dropped (R1)
    chk("R1 pre-start dropped", 64'(fifo_empty), 64'd1);
    send_sof();
    put(0, 8'h01); put(0, 8'h02); put(1, 8'h1C); put(0, 8'h03); put(0, 8'h04);
    put(0, 8'h05); put(0, 8'h06); put(0, 8'h07); put(0, 8'h08);
    put(1, 8'hFD);
    chk("R3 no irq mid-delimiter", 64'(frame_irq), 64'd0);
    put(1, 8'hFE);
    chk("R3 irq pulse", 64'(frame_irq), 64'd1);
    @(negedge clk);
    chk("R3 irq single cycle", 64'(frame_irq), 64'd0);
    pop("R4 word0", 32'h04030201, 3'd4);
    pop("R4 word1", 32'h08070605, 3'd4);
    chk("R4 nothing else", 64'(fifo_empty), 64'd1);
  endtask

  task automatic t_flush();
    do_reset(1'b1);
    send_sof();
    put(0, 8'hA1); put(1, 8'h1C); put(0, 8'hA2); put(0, 8'hA3);
    put(1, 8'hFD); put(1, 8'hFE);
    chk("R6 irq on partial frame", 64'(frame_irq), 64'd1);
    pop("R6 partial word", 32'h00A3A2A1, 3'd3);
    chk("R6 single word", 64'(fifo_empty), 64'd1);
  endtask

  task automatic t_restart();
    do_reset(1'b1);
    put(1, 8'hBC); put(1, 8'h3C); put(1, 8'hBC); put(1, 8'h3C); put(1, 8'h7C);
    put(0, 8'h55);
    put(1, 8'hFD); put(1, 8'hFE);
    chk("R2 frame after restart irq", 64'(frame_irq), 64'd1);
    pop("R2 frame after restart", 32'h00000055, 3'd1);
    // a data byte with a delimiter value does not count
    put(1, 8'hBC); put(0, 8'h3C); put(1, 8'h7C); put(0, 8'h66);
    put(1, 8'hFD); put(1, 8'hFE);
    chk("R1 non-K byte breaks start", 64'(fifo_empty), 64'd1);
  endtask

  task automatic t_raw();
    do_reset(1'b0);
    put(0, 8'h12); put(1, 8'h1C); put(0, 8'h34);
    pop("R5 raw pre-frame", 32'h00D23812, 3'd3);
    send_sof();
    pop("R5 raw delimiter kept", 32'h05F279BC, 3'd3);
    put(0, 8'h99); put(0, 8'h98); put(1, 8'hFD); put(1, 8'hFE);
    chk("R3 raw irq", 64'(frame_irq), 64'd1);
    pop("R5 raw full", 32'h07F53099, 3'd3);
    pop("R6 raw flush", 32'h000001FE, 3'd1);
  endtask

  task automatic t_overflow();
    do_reset(1'b1);
    send_sof();
    for (int i = 0; i < 68; i++) put(0, 8'(i));
    chk("R7 overrun set", 64'(overrun), 64'd1);
    put(0, 8'h77); put(0, 8'h78); put(1, 8'hFD); put(1, 8'hFE);
    chk("R7 no irq for lost frame", 64'(frame_irq), 64'd0);
    for (int w = 0; w < 16; w++) begin
      logic [31:0] e;
      e = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
      pop("R7 stored word", e, 3'd4);
    end
    chk("R7 drained", 64'(fifo_empty), 64'd1);
    put(1, 8'hBC); put(0, 8'h44); put(0, 8'h45); put(0, 8'h46); put(0, 8'h47);
    chk("R7 dropped until start", 64'(fifo_empty), 64'd1);
    put(1, 8'h3C); put(1, 8'hFD); put(1, 8'hFE);
    send_sof();
    put(0, 8'hC1); put(0, 8'hC2); put(1, 8'hFD); put(1, 8'hFE);
    chk("R7 resume irq", 64'(frame_irq), 64'd1);
    pop("R7 resumed", 32'h0000C2C1, 3'd2);
    chk("R7 sticky", 64'(overrun), 64'd1);
  endtask

  task automatic t_loop();
    do_reset(1'b1);
    cfg_loop = 1'b1;
    tx_valid = 1'b1; tx_data = 32'hDEADBEEF; @(negedge clk); tx_valid = 1'b0;
    send_sof();
    put(0, 8'h21); put(0, 8'h22); put(0, 8'h23); put(0, 8'h24);
    put(1, 8'hFD); put(1, 8'hFE);
    chk("R8 bytes raise no irq", 64'(frame_irq), 64'd0);
    tx_valid = 1'b1; tx_data = 32'h00C0FFEE; @(negedge clk); tx_valid = 1'b0;
    pop("R8 loop word0", 32'hDEADBEEF, 3'd4);
    pop("R10 loop word1 order", 32'h00C0FFEE, 3'd4);
    chk("R8 bytes ignored", 64'(fifo_empty), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sof_len = 2'd3; sof_seq = {8'h7C, 8'h3C, 8'hBC};
    eof_len = 2'd2; eof_seq = {8'h00, 8'hFE, 8'hFD};
    t_reset();
    t_packed();
    t_flush();
    t_restart();
    t_raw();
    t_overflow();
    t_loop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule